// File: doc/BRIEF.md
# Multi-Channel Serial-Bus Interrupt Status Aggregator

This block keeps the interrupt enable and sticky event status registers for a set of two-wire serial bus channels and drives one interrupt line per channel. Each channel's bus engine reports events through one-cycle set pulses, one bit per event kind. The engine then issues a raise request. A raise keeps only the enabled status bits, so disabled events are thrown away rather than left pending. If anything survives the mask, the channel's line goes high and its bit in a shared read-only summary register is set.

Software reads and writes the registers through a simple request port. Read data comes back one cycle after the request. Status bits are cleared by writing ones to them. When a clear leaves a channel's status empty, its line and summary bit drop.

Clearing the receive-done event while the engine still has a receive command outstanding has an extra effect. The block sends the engine a one-cycle continue pulse. In the following cycle it evaluates the channel's interrupt again, as if a raise had been requested.

Top module: `i2c_irq_agg`

## Requirements
- R1: After reset every enable, status and summary bit reads 0, and every irq and rx_continue output is 0. A write to a channel's enable register (address bits [1:0] = 0) stores only data bits 14:0, and the register reads back with bits 31:15 equal to zero.
- R2: A set pulse on ev_set bit (16*0 + 15*ch + k) sets bit k of that channel's status at the next clock edge. The bit stays set until software clears it. A set pulse without a raise never changes the channel's irq line. The event bits are: 0 TX acknowledged, 1 TX not acknowledged, 2 receive done, 3 arbitration lost, 4 normal stop, 5 abnormal stop, 6 clock-low timeout.
- R3: A write to a channel's status register (address bits [1:0] = 1) clears every status bit whose data bit is 1. If a set pulse hits the same bit in the same cycle, the set pulse wins.
- R4: A raise, either from ev_raise or internal, ANDs the channel's status with its enable register. The status bits that were disabled before the raise read 0 afterwards.
- R5: When a raise leaves the channel's status nonzero, that channel's irq line and its summary bit are 1 from the next cycle.
- R6: When a status write leaves the channel's status all zero, that channel's irq line and summary bit are 0 from the next cycle. A status write that leaves any bit set does not change them.
- R7: A status write that clears bit 2 while that bit was set and rx_pending is high gives one cycle of rx_continue for that channel in the next cycle. In that cycle the channel performs a raise. No pulse is produced if rx_pending is low or if bit 2 was already clear.
- R8: The summary register (address bits [1:0] = 2, channel field ignored) has bit c equal to channel c's irq line. Writes to it have no effect.
- R9: The address holds the register select in bits [1:0] and the channel in the bits above. Select 3, or a channel number that does not exist, reads 0. A read request returns data on reg_rdata at the next clock edge, and reg_rdata holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | {channel, select[1:0]} |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, one cycle after the request |
| ev_set | input | NUM_CH*EV_W | Per-channel event set pulses |
| ev_raise | input | NUM_CH | Per-channel raise request |
| rx_pending | input | NUM_CH | Receive command outstanding in the engine |
| rx_continue | output | NUM_CH | One-cycle pulse to resume a pending receive |
| irq | output | NUM_CH | Per-channel interrupt line |

## Verification
Every state change in this block is registered once. Status, enable, summary, irq and rx_continue all show the effect of a pulse or write at the first clock edge after it. Read data shows up at the edge that samples the request. The re-run raise that follows a continue pulse lands one edge after the pulse. The bench drives inputs on the falling edge and samples on the next falling edge. A monitor pops the expected read values at exactly that edge. The continue pulse and its follow-on raise are checked on two consecutive falling edges, so a one-cycle slip in either is caught.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

  typedef enum logic [1:0] {
    SEL_ENABLE  = 2'd0,
    SEL_STATUS  = 2'd1,
    SEL_SUMMARY = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

  localparam int unsigned EVB_TX_ACK   = 0;
  localparam int unsigned EVB_TX_NAK   = 1;
  localparam int unsigned EVB_RX_DONE  = 2;
  localparam int unsigned EVB_ARB_LOST = 3;
  localparam int unsigned EVB_STOP_OK  = 4;
  localparam int unsigned EVB_STOP_BAD = 5;
  localparam int unsigned EVB_SCL_TMO  = 6;

endpackage

// File: rtl/irq_chan_regs.sv
module irq_chan_regs #(
  parameter int unsigned EV_W    = 15,
  parameter int unsigned RXD_BIT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_wr,
  input  logic            st_wr,
  input  logic [EV_W-1:0] wdata,
  input  logic [EV_W-1:0] set_pulse,
  input  logic            raise_in,
  input  logic            rx_pending,
  output logic [EV_W-1:0] en_q,
  output logic [EV_W-1:0] st_q,
  output logic            flag_q,
  output logic            cont_q
);

  logic [EV_W-1:0] clr_mask;
  logic [EV_W-1:0] st_pre;
  logic [EV_W-1:0] st_d;
  logic            raise_eff;
  logic            flag_d;
  logic            cont_d;

  // next-state logic
  always_comb begin
    clr_mask  = st_wr ? wdata : '0;
    st_pre    = (st_q & ~clr_mask) | set_pulse;
    raise_eff = raise_in | cont_q;
    st_d      = raise_eff ? (st_pre & en_q) : st_pre;
    flag_d    = flag_q;
    if (raise_eff && (st_d != '0)) begin
      flag_d = 1'b1;
    end else if (st_wr && (st_d == '0)) begin
      flag_d = 1'b0;
    end
    cont_d = st_wr && wdata[RXD_BIT] && st_q[RXD_BIT] && rx_pending;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_wr) begin
      en_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      flag_q <= 1'b0;
      cont_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      flag_q <= flag_d;
      cont_q <= cont_d;
    end
  end

  assert_en_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (en_q == $past(wdata)));

  assert_set_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!raise_eff && (set_pulse != '0)) |=> ((st_q & $past(set_pulse)) == $past(set_pulse)));

  assert_raise_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    raise_eff |=> ((st_q & ~$past(en_q)) == '0));

  assert_raise_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_in && !st_wr && (((st_q | set_pulse) & en_q) != '0)) |=> flag_q);

  assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !raise_eff && (((st_q & ~wdata) | set_pulse) == '0)) |=> !flag_q);

  assert_cont_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cont_q) |-> $past(st_wr && wdata[RXD_BIT] && st_q[RXD_BIT] && rx_pending));

endmodule

// File: rtl/irq_rd_port.sv
module irq_rd_port #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned EV_W   = 15,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CH_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_req,
  input  i2c_irq_pkg::reg_sel_e          sel,
  input  logic [CH_W-1:0]                chan,
  input  logic [NUM_CH-1:0][EV_W-1:0]    en_all,
  input  logic [NUM_CH-1:0][EV_W-1:0]    st_all,
  input  logic [NUM_CH-1:0]              flags,
  output logic [DATA_W-1:0]              rdata
);
  import i2c_irq_pkg::*;

  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    case (sel)
      SEL_ENABLE: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (chan == CH_W'(c)) rd_d = DATA_W'(en_all[c]);
        end
      end
      SEL_STATUS: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (chan == CH_W'(c)) rd_d = DATA_W'(st_all[c]);
        end
      end
      SEL_SUMMARY: rd_d = DATA_W'(flags);
      default:     rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_req) begin
      rdata <= rd_d;
    end
  end

endmodule

// File: rtl/i2c_irq_agg.sv
module i2c_irq_agg #(
  parameter  int unsigned NUM_CH = 4,
  parameter  int unsigned EV_W   = 15,
  parameter  int unsigned DATA_W = 32,
  localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned ADDR_W = CH_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_valid,
  input  logic                     reg_write,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  input  logic [NUM_CH*EV_W-1:0]   ev_set,
  input  logic [NUM_CH-1:0]        ev_raise,
  input  logic [NUM_CH-1:0]        rx_pending,
  output logic [NUM_CH-1:0]        rx_continue,
  output logic [NUM_CH-1:0]        irq
);
  import i2c_irq_pkg::*;

  reg_sel_e                  sel;
  logic [CH_W-1:0]           chan;
  logic                      wr_req;
  logic                      rd_req;
  logic [EV_W-1:0]           wd_ev;
  logic                      wdata_unused;
  logic [NUM_CH-1:0][EV_W-1:0] en_all;
  logic [NUM_CH-1:0][EV_W-1:0] st_all;
  logic [NUM_CH-1:0]         flags;
  logic [NUM_CH-1:0]         cont;

  always_comb begin
    sel    = reg_sel_e'(reg_addr[1:0]);
    chan   = reg_addr[ADDR_W-1:2];
    wr_req = reg_valid && reg_write;
    rd_req = reg_valid && !reg_write;
    wd_ev  = reg_wdata[EV_W-1:0];
  end

  assign wdata_unused = ^reg_wdata[DATA_W-1:EV_W];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic hit;
    logic en_wr;
    logic st_wr;

    always_comb begin
      hit   = wr_req && (chan == CH_W'(c));
      en_wr = hit && (sel == SEL_ENABLE);
      st_wr = hit && (sel == SEL_STATUS);
    end

    irq_chan_regs #(
      .EV_W    (EV_W),
      .RXD_BIT (EVB_RX_DONE)
    ) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_wr      (en_wr),
      .st_wr      (st_wr),
      .wdata      (wd_ev),
      .set_pulse  (ev_set[c*EV_W +: EV_W]),
      .raise_in   (ev_raise[c]),
      .rx_pending (rx_pending[c]),
      .en_q       (en_all[c]),
      .st_q       (st_all[c]),
      .flag_q     (flags[c]),
      .cont_q     (cont[c])
    );
  end

  irq_rd_port #(
    .NUM_CH (NUM_CH),
    .EV_W   (EV_W),
    .DATA_W (DATA_W),
    .CH_W   (CH_W)
  ) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_req (rd_req),
    .sel    (sel),
    .chan   (chan),
    .en_all (en_all),
    .st_all (st_all),
    .flags  (flags),
    .rdata  (reg_rdata)
  );

  assign irq         = flags;
  assign rx_continue = cont;

endmodule

// File: tb/i2c_irq_agg_tb_top.sv
module i2c_irq_agg_tb_top;
  localparam int NCH = 4;
  localparam int EVW = 15;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_valid = 1'b0;
  logic            reg_write = 1'b0;
  logic [3:0]      reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NCH*EVW-1:0] ev_set = '0;
  logic [NCH-1:0]  ev_raise = '0;
  logic [NCH-1:0]  rx_pending = '0;
  logic [NCH-1:0]  rx_continue;
  logic [NCH-1:0]  irq;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic rd_seen = 1'b0;

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t sbq[$];

  always #10 clk = ~clk;

  i2c_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_set(ev_set), .ev_raise(ev_raise), .rx_pending(rx_pending),
    .rx_continue(rx_continue), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard queue
  always @(posedge clk) rd_seen <= rst_n && reg_valid && !reg_write;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (sbq.size() == 0) begin
        total++; bad++;
        $display("FAIL R9 unexpected read data actual=0x%0h expected=none", reg_rdata);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(e.tag, reg_rdata, e.val);
      end
    end
  end

  task automatic do_write(int ch, int sel, logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b1;
    reg_addr = 4'((ch << 2) | sel); reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic do_read(int ch, int sel, logic [31:0] exp, string tag);
    exp_t e;
    e.val = exp; e.tag = tag;
    sbq.push_back(e);
    reg_valid = 1'b1; reg_write = 1'b0;
    reg_addr = 4'((ch << 2) | sel);
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic pulse(int ch, logic [14:0] bits, logic rz);
    ev_set[ch*EVW +: EVW] = bits;
    ev_raise[ch] = rz;
    @(negedge clk);
    ev_set = '0; ev_raise = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 rx_continue after reset", 32'(rx_continue), 0);
    do_read(0, 0, 0, "R1 enable reset");
    do_read(0, 1, 0, "R2 status reset");
    do_read(0, 2, 0, "R8 summary reset");
    // R1 enable width
    do_write(0, 0, 32'hFFFF_FFFF);
    do_read(0, 0, 32'h7FFF, "R1 enable keeps 14:0");
    do_read(0, 3, 0, "R9 select 3 reads zero");
    // R2 sticky set, no line without raise
    pulse(0, 15'h0011, 1'b0);
    chk("R2 no irq without raise", 32'(irq), 0);
    do_read(0, 1, 32'h11, "R2 sticky status");
    // R5 raise
    pulse(0, 15'h0, 1'b1);
    chk("R5 irq after raise", 32'(irq), 32'h1);
    do_read(0, 2, 32'h1, "R5 summary bit");
    // R3 / R6 clear
    do_write(0, 1, 32'h1);
    chk("R6 irq kept on partial clear", 32'(irq), 32'h1);
    do_read(0, 1, 32'h10, "R3 partial clear");
    do_write(0, 1, 32'h10);
    chk("R6 irq drops on empty status", 32'(irq), 0);
    do_read(0, 2, 0, "R6 summary cleared");
    // R3 set wins over clear
    ev_set[0 +: EVW] = 15'h0040;
    do_write(0, 1, 32'h40);
    ev_set = '0;
    do_read(0, 1, 32'h40, "R3 set wins");
    chk("R2 set without raise keeps line low", 32'(irq), 0);
    do_write(0, 1, 32'h40);
    do_read(0, 1, 0, "R3 cleared after collision");
    // R4 masking on channel 1
    do_write(1, 0, 32'h4);
    pulse(1, 15'h000A, 1'b1);
    chk("R4 disabled events no irq", 32'(irq), 0);
    do_read(1, 1, 0, "R4 disabled events discarded");
    pulse(1, 15'h0006, 1'b1);
    chk("R5 enabled event raises ch1", 32'(irq), 32'h2);
    do_read(1, 1, 32'h4, "R4 only enabled bit left");
    // R8 summary read-only
    do_write(0, 2, 32'h0);
    do_write(2, 2, 32'hF);
    do_read(3, 2, 32'h2, "R8 summary write ignored");
    // R7 continue receive
    rx_pending[1] = 1'b1;
    do_write(1, 1, 32'h4);
    chk("R7 continue pulse", 32'(rx_continue), 32'h2);
    chk("R6 line low after rx clear", 32'(irq), 0);
    pulse(1, 15'h0004, 1'b0);
    chk("R7 continue is one cycle", 32'(rx_continue), 0);
    chk("R7 re-evaluated raise", 32'(irq), 32'h2);
    do_read(1, 1, 32'h4, "R7 status after re-raise");
    rx_pending[1] = 1'b0;
    do_write(1, 1, 32'h4);
    chk("R7 no pulse without pending", 32'(rx_continue), 0);
    rx_pending[1] = 1'b1;
    do_write(1, 1, 32'h4);
    chk("R7 no pulse when bit already clear", 32'(rx_continue), 0);
    rx_pending[1] = 1'b0;
    chk("R6 ch1 line low", 32'(irq), 0);
    // R9 channel isolation
    do_write(2, 0, 32'h7FFF);
    pulse(2, 15'h0020, 1'b1);
    chk("R5 ch2 line only", 32'(irq), 32'h4);
    do_read(2, 2, 32'h4, "R8 summary ch2");
    do_read(0, 1, 0, "R9 ch0 untouched by ch2");
    do_read(2, 1, 32'h20, "R9 ch2 status");
    repeat (2) @(negedge clk);
    if (sbq.size() != 0) begin
      total++; bad++;
      $display("FAIL R9 missing read data actual=%0d expected=0", sbq.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule